// File: doc/BRIEF.md
# Min-Max, Negated-Logic and Pack Unit

This block is a purely combinational 32-bit datapath for a group of bit-manipulation operations: signed and unsigned minimum and maximum, the three logic operations that take the inverse of the second operand, and three half-word or byte packing operations. Two operands and a 4-bit operation code come in. The 32-bit result goes out in the same cycle. There are no registers and no handshake.

A single 33-bit subtractor decides which operand is smaller. A signedness control selects how the 33rd bit is extended. The comparison result then steers one two-way operand mux for all four min/max codes. The inverted second operand that feeds the subtractor also feeds the AND, OR and XOR gates, which turns them into and-not, or-not and xnor.

The unit has no state machine. A small decoder turns the operation code into a control word, and the control word picks the result group: none, min/max, logic or pack.

Top module: `minmax_pack_unit`

## Requirements
- R1: Code 0 (signed minimum) returns whichever operand is smaller when both are read as two's-complement values.
- R2: Code 1 (unsigned minimum) returns whichever operand is smaller when both are read as unsigned values.
- R3: Code 2 (signed maximum) returns whichever operand is larger when both are read as two's-complement values.
- R4: Code 3 (unsigned maximum) returns whichever operand is larger when both are read as unsigned values.
- R5: For codes 0 to 3 with equal operands, the result is that common value.
- R6: Code 4 (and-not) returns A & ~B.
- R7: Code 5 (or-not) returns A | ~B.
- R8: Code 6 (xnor) returns ~(A ^ B).
- R9: Code 7 (pack low halves) returns A[15:0] in result bits 15:0 and B[15:0] in result bits 31:16.
- R10: Code 8 (pack high halves) returns A[31:16] in result bits 15:0 and B[31:16] in result bits 31:16.
- R11: Code 9 (pack bytes) returns A[7:0] in result bits 7:0 and B[7:0] in bits 15:8, with bits 31:16 zero.
- R12: Codes 10 to 15 return zero for any operands.
- R13: The result follows the present operands and code without any clock edge, so a change to the inputs shows at the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand (A) |
| opb_i | input | 32 | Second operand (B) |
| op_sel_i | input | 4 | Operation code, values as in the requirements |
| result_o | output | 32 | Operation result |

## Verification
Every result is due with zero latency, because no register lies between the inputs and the output. The bench drives the operands and the code 1 ns after a rising edge and compares the output at the following falling edge, within the same cycle. Each comparison is against a behavioural model built from integer and `$signed` arithmetic. Signed boundary values are swept over every code, and so are equal operand pairs. One check changes the inputs between two edges with no clock edge in between, to show the output moves at once.

// File: rtl/mpl_pkg.sv
package mpl_pkg;

    localparam int unsigned OP_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_MIN   = 4'd0,
        OP_MINU  = 4'd1,
        OP_MAX   = 4'd2,
        OP_MAXU  = 4'd3,
        OP_ANDN  = 4'd4,
        OP_ORN   = 4'd5,
        OP_XNOR  = 4'd6,
        OP_PACK  = 4'd7,
        OP_PACKU = 4'd8,
        OP_PACKH = 4'd9
    } mpl_op_e;

    typedef enum logic [1:0] {
        GRP_NONE   = 2'd0,
        GRP_MINMAX = 2'd1,
        GRP_LOGIC  = 2'd2,
        GRP_PACK   = 2'd3
    } mpl_grp_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } mpl_logic_e;

    typedef enum logic [1:0] {
        PK_LOW  = 2'd0,
        PK_HIGH = 2'd1,
        PK_BYTE = 2'd2
    } mpl_pack_e;

    typedef struct packed {
        mpl_grp_e   grp;
        logic       cmp_signed;
        logic       pick_max;
        mpl_logic_e lg_kind;
        mpl_pack_e  pk_kind;
    } mpl_ctrl_t;

endpackage

// File: rtl/mpl_decode.sv
module mpl_decode
    import mpl_pkg::*;
(
    input  logic [OP_BITS-1:0] op_i,
    output mpl_ctrl_t          ctrl_o
);

    always_comb begin
        ctrl_o = '{grp: GRP_NONE, cmp_signed: 1'b0, pick_max: 1'b0,
                   lg_kind: LG_AND, pk_kind: PK_LOW};
        case (op_i)
            OP_MIN:   begin ctrl_o.grp = GRP_MINMAX; ctrl_o.cmp_signed = 1'b1; end
            OP_MINU:  begin ctrl_o.grp = GRP_MINMAX; end
            OP_MAX:   begin ctrl_o.grp = GRP_MINMAX; ctrl_o.cmp_signed = 1'b1;
                            ctrl_o.pick_max = 1'b1; end
            OP_MAXU:  begin ctrl_o.grp = GRP_MINMAX; ctrl_o.pick_max = 1'b1; end
            OP_ANDN:  begin ctrl_o.grp = GRP_LOGIC;  ctrl_o.lg_kind = LG_AND; end
            OP_ORN:   begin ctrl_o.grp = GRP_LOGIC;  ctrl_o.lg_kind = LG_OR;  end
            OP_XNOR:  begin ctrl_o.grp = GRP_LOGIC;  ctrl_o.lg_kind = LG_XOR; end
            OP_PACK:  begin ctrl_o.grp = GRP_PACK;   ctrl_o.pk_kind = PK_LOW;  end
            OP_PACKU: begin ctrl_o.grp = GRP_PACK;   ctrl_o.pk_kind = PK_HIGH; end
            OP_PACKH: begin ctrl_o.grp = GRP_PACK;   ctrl_o.pk_kind = PK_BYTE; end
            default:  begin ctrl_o.grp = GRP_NONE; end
        endcase
    end

endmodule

// File: rtl/mpl_minmax.sv
module mpl_minmax #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] b_inv_i,
    input  logic             signed_i,
    input  logic             pick_max_i,
    output logic [WIDTH-1:0] res_o
);

    localparam int unsigned EXT = WIDTH + 1;

    logic           a_ext_bit;
    logic           b_ext_bit;
    logic [EXT-1:0] diff;
    logic           a_less;

    // One shared subtractor: A + ~B + 1, widened by one bit
    always_comb begin
        a_ext_bit = signed_i & a_i[WIDTH-1];
        b_ext_bit = signed_i & b_i[WIDTH-1];
        diff      = {a_ext_bit, a_i} + {~b_ext_bit, b_inv_i} + EXT'(1);
        a_less    = diff[EXT-1];
    end

    always_comb begin
        if (a_less ^ pick_max_i) res_o = a_i;
        else                     res_o = b_i;
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, signed_i, pick_max_i})) begin
            // R2
            cmp_unsigned_chk: assert (signed_i || (a_less == (a_i < b_i)));
            // R1
            cmp_signed_chk: assert (!signed_i || (a_less == ($signed(a_i) < $signed(b_i))));
            // R5
            minmax_pick_chk: assert ((res_o == a_i) || (res_o == b_i));
        end
    end

endmodule

// File: rtl/mpl_neglogic.sv
module mpl_neglogic
    import mpl_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_inv_i,
    input  mpl_logic_e       kind_i,
    output logic [WIDTH-1:0] res_o
);

    always_comb begin
        unique case (kind_i)
            LG_AND:  res_o = a_i & b_inv_i;
            LG_OR:   res_o = a_i | b_inv_i;
            LG_XOR:  res_o = a_i ^ b_inv_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/mpl_pack.sv
module mpl_pack
    import mpl_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned BYTE  = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  mpl_pack_e        kind_i,
    output logic [WIDTH-1:0] res_o
);

    localparam int unsigned HALF = WIDTH / 2;

    logic [WIDTH-1:0] low_pk;
    logic [WIDTH-1:0] high_pk;
    logic [WIDTH-1:0] byte_pk;

    always_comb begin
        low_pk  = {b_i[HALF-1:0], a_i[HALF-1:0]};
        high_pk = {b_i[WIDTH-1:HALF], a_i[WIDTH-1:HALF]};
        byte_pk = {{(WIDTH-2*BYTE){1'b0}}, b_i[BYTE-1:0], a_i[BYTE-1:0]};
    end

    always_comb begin
        unique case (kind_i)
            PK_LOW:  res_o = low_pk;
            PK_HIGH: res_o = high_pk;
            PK_BYTE: res_o = byte_pk;
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, kind_i})) begin
            // R11
            packh_top_clear_chk: assert ((kind_i != PK_BYTE) || (res_o[WIDTH-1:2*BYTE] == '0));
        end
    end

endmodule

// File: rtl/minmax_pack_unit.sv
module minmax_pack_unit
    import mpl_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned BYTE  = 8
) (
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    input  logic [OP_BITS-1:0] op_sel_i,
    output logic [WIDTH-1:0]   result_o
);

    mpl_ctrl_t        ctrl;
    logic [WIDTH-1:0] b_inv;
    logic [WIDTH-1:0] mm_res;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] pk_res;

    // Inverted second operand, shared by subtractor and negate logic
    assign b_inv = ~opb_i;

    mpl_decode u_decode (
        .op_i   (op_sel_i),
        .ctrl_o (ctrl)
    );

    mpl_minmax #(.WIDTH(WIDTH)) u_minmax (
        .a_i        (opa_i),
        .b_i        (opb_i),
        .b_inv_i    (b_inv),
        .signed_i   (ctrl.cmp_signed),
        .pick_max_i (ctrl.pick_max),
        .res_o      (mm_res)
    );

    mpl_neglogic #(.WIDTH(WIDTH)) u_neglogic (
        .a_i     (opa_i),
        .b_inv_i (b_inv),
        .kind_i  (ctrl.lg_kind),
        .res_o   (lg_res)
    );

    mpl_pack #(.WIDTH(WIDTH), .BYTE(BYTE)) u_pack (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .kind_i (ctrl.pk_kind),
        .res_o  (pk_res)
    );

    always_comb begin
        unique case (ctrl.grp)
            GRP_MINMAX: result_o = mm_res;
            GRP_LOGIC:  result_o = lg_res;
            GRP_PACK:   result_o = pk_res;
            default:    result_o = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({opa_i, opb_i, op_sel_i})) begin
            // R8
            xnor_parity_chk: assert ((op_sel_i != OP_XNOR) || ((result_o ^ opa_i ^ opb_i) == '1));
            // R12
            unknown_zero_chk: assert ((op_sel_i <= OP_PACKH) || (result_o == '0));
            // R6
            andn_clear_chk: assert ((op_sel_i != OP_ANDN) || ((result_o & opb_i) == '0));
        end
    end

endmodule

// File: tb/minmax_pack_unit_bench.sv
`timescale 1ns/1ps
module minmax_pack_unit_bench;

    logic        clk = 1'b0;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [3:0]  op;
    logic [31:0] res;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    minmax_pack_unit u_minmax_pack_unit (
        .opa_i    (opa),
        .opb_i    (opb),
        .op_sel_i (op),
        .result_o (res)
    );

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, int code);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        case (code)
            0:  return (sa < sb) ? a : b;
            1:  return (a < b) ? a : b;
            2:  return (sa > sb) ? a : b;
            3:  return (a > b) ? a : b;
            4:  return a & ~b;
            5:  return a | ~b;
            6:  return ~(a ^ b);
            7:  return {b[15:0], a[15:0]};
            8:  return {b[31:16], a[31:16]};
            9:  return {16'h0000, b[7:0], a[7:0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [31:0] a, logic [31:0] b, int code);
        if (code <= 3 && a == b) return "R5";
        case (code)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R9";
            8: return "R10";
            9: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic compare(string tag, logic [31:0] a, logic [31:0] b, int code);
        logic [31:0] exp_v = model(a, b, code);
        n_vec++;
        if (res !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, code, a, b, res, exp_v);
        end
    endtask

    // Drive 1 ns after the rising edge, compare on the falling edge (same cycle)
    task automatic run_vec(logic [31:0] a, logic [31:0] b, int code);
        @(posedge clk);
        #1;
        opa = a; opb = b; op = 4'(code);
        @(negedge clk);
        compare(tag_of(a, b, code), a, b, code);
    endtask

    logic [31:0] edge_vals [7] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                                   32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
                                   32'h8000_0001};

    initial begin
        opa = '0; opb = '0; op = '0;
        @(negedge clk);
        // Initial state: zero operands, signed min gives zero (R1)
        compare("R1", 32'h0, 32'h0, 0);

        // Signed and unsigned boundary sweep over every code
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
                for (int c = 0; c < 16; c++)
                    run_vec(edge_vals[i], edge_vals[j], c);

        // Equal operands for min/max (R5)
        for (int k = 0; k < 4; k++)
            run_vec(32'hDEAD_BEEF, 32'hDEAD_BEEF, k);

        // R13: inputs change mid-cycle, no clock edge, output follows at once
        @(posedge clk);
        #0.5;
        opa = 32'h8000_0000; opb = 32'h0000_0005; op = 4'd0;
        #0.5;
        compare("R13", 32'h8000_0000, 32'h0000_0005, 0);
        opa = 32'hA5A5_00FF; opb = 32'h5A5A_1234; op = 4'd9;
        #0.5;
        compare("R13", 32'hA5A5_00FF, 32'h5A5A_1234, 9);

        // Pseudo-random operands over every code
        void'($urandom(32'd7));
        for (int r = 0; r < 1500; r++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            for (int c = 0; c < 16; c++)
                run_vec(ra, rb, c);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d cycles expected=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule